// File: doc/BRIEF.md
# PCI Base Address Register Bank

This block holds the six base address registers of a PCI Type 0 configuration header. The host programs them over a dword-wide configuration port. Each register has a static mask, set by parameter. The mask fixes how large the decoded window is and what kind of space it maps. From these masks the block decides, at elaboration, which registers are idle, which decode I/O space (16-bit or 32-bit) and which decode memory space (32-bit, below 1 MB, or a 64-bit window spread across two adjacent registers).

Host writes are masked, so only the programmable address bits move. The type bits and prefetch bits are always read back from the mask. A write of all ones is treated as a size probe: the masked value is stored so the host can read the window size back, but nothing else happens. Any other write to a live register produces a one-cycle change pulse carrying the register index, which a downstream address decoder uses to remap the window. A mask set that cannot be honoured raises a sticky error flag, and the offending registers then act as idle.

Top module: `pci_bar_bank`

## Requirements
- R1: Offsets 0x10 through 0x27 select a register with index (offset − 0x10) >> 2, and offset bits [1:0] are ignored. A read outside that range is not claimed: `cfg_rvalid` stays low and `cfg_rdata` is zero.
- R2: After reset, every register holds only its fixed low bits and all programmable address bits are zero. The fixed low bits are mask[1:0] for I/O, mask[3:0] for a memory register or the low half of a 64-bit pair, and zero for an upper half or an idle register.
- R3: A register whose mask is zero is idle. Writes to it change nothing, it reads as zero, and it raises no change pulse.
- R4: Mask bit 0 set marks an I/O register. A write stores (data & mask & ~3) | (mask & 3).
- R5: A memory register, with mask bit 0 clear and mask bits [2:1] equal to 0 (32-bit), 1 (below 1 MB) or 2 (low half of a 64-bit window), stores (data & mask & ~0xF) | (mask & 0xF).
- R6: The register following a valid 64-bit low half is its upper half. It stores data & mask, with no fixed bits, whatever its own mask's low bits are.
- R7: Three mask sets are errors: memory type 3, a 64-bit type in the last register, and a 64-bit type whose next mask is zero. Any of them sets `cfg_err` in the first cycle after reset is released. The flag stays set until the next reset, and the offending register behaves as idle.
- R8: A write of 0xFFFFFFFF stores the masked value, so the host reads back the size, and it raises no change pulse.
- R9: Any other write to a live register sets `chg_pulse` for exactly the cycle after the write, with `chg_idx` equal to the register index.
- R10: A claimed read returns the stored value on `cfg_rdata`, with `cfg_rvalid` high, in the cycle after `cfg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read claimed by this block |
| chg_pulse | output | 1 | One-cycle register change notification |
| chg_idx | output | 3 | Index of the changed register |
| cfg_err | output | 1 | Sticky mask configuration error |

## Verification
The assertions assume that the strobes and the address are driven from registered logic and are stable around the clock edge. They also assume that a read and a write never target the same register in the same cycle, because that case returns the old value. The stimulus keeps to these assumptions by driving every input on the falling edge and by issuing reads and writes in separate cycles. Reset is held for several cycles with both strobes low, so the past-value checks that run in the first cycle after reset see idle inputs.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;
  typedef enum logic [2:0] {
    BT_NONE,
    BT_IO16,
    BT_IO32,
    BT_MEM20,
    BT_MEM32,
    BT_MEM64LO,
    BT_MEM64HI
  } bar_type_e;
endpackage

// File: rtl/bar_addr_decode.sv
module bar_addr_decode #(
  parameter int AW        = 8,
  parameter int NUM_BARS  = 6,
  parameter int BASE_OFFS = 16,
  localparam int IDX_W    = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam int FIRST_I = BASE_OFFS / 4;
  localparam logic [AW-3:0] FIRST = FIRST_I[AW-3:0];
  localparam logic [AW-3:0] COUNT = NUM_BARS[AW-3:0];

  logic [AW-3:0] word;
  logic [AW-3:0] diff;

  always_comb begin
    word = addr[AW-1:2];
    diff = word - FIRST;
    hit  = (word >= FIRST) && (diff < COUNT);
    idx  = diff[IDX_W-1:0];
  end
endmodule

// File: rtl/bar_classify.sv
module bar_classify
  import pci_bar_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NUM_BARS = 6,
  parameter logic [NUM_BARS*DW-1:0] MASKS = '0
) (
  output bar_type_e typ [NUM_BARS],
  output logic      err
);
  logic [DW-1:0] mk [NUM_BARS+1];

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_mask
    assign mk[g] = MASKS[g*DW +: DW];
  end
  assign mk[NUM_BARS] = '0;

  always_comb begin
    logic pair_hi;
    pair_hi = 1'b0;
    err     = 1'b0;
    for (int i = 0; i < NUM_BARS; i++) begin
      typ[i] = BT_NONE;
      if (pair_hi) begin
        typ[i]  = BT_MEM64HI;
        pair_hi = 1'b0;
      end else if (mk[i] == '0) begin
        typ[i] = BT_NONE;
      end else if (mk[i][0]) begin
        typ[i] = (|mk[i][DW-1:16]) ? BT_IO32 : BT_IO16;
      end else begin
        case (mk[i][2:1])
          2'd0: typ[i] = BT_MEM32;
          2'd1: typ[i] = BT_MEM20;
          2'd2: begin
            if (i == NUM_BARS - 1 || mk[i+1] == '0) begin
              err = 1'b1;
            end else begin
              typ[i]  = BT_MEM64LO;
              pair_hi = 1'b1;
            end
          end
          default: err = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/bar_slot.sv
module bar_slot
  import pci_bar_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [DW-1:0] MASK = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  bar_type_e     typ,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] value
);
  localparam logic [DW-1:0] IO_LO  = DW'(3);
  localparam logic [DW-1:0] MEM_LO = DW'(15);

  logic [DW-1:0] fixed;
  logic [DW-1:0] prog;

  always_comb begin
    case (typ)
      BT_IO16, BT_IO32: begin
        fixed = MASK & IO_LO;
        prog  = MASK & ~IO_LO;
      end
      BT_MEM20, BT_MEM32, BT_MEM64LO: begin
        fixed = MASK & MEM_LO;
        prog  = MASK & ~MEM_LO;
      end
      BT_MEM64HI: begin
        fixed = '0;
        prog  = MASK;
      end
      default: begin
        fixed = '0;
        prog  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= fixed;
    end else if (wr_en && typ != BT_NONE) begin
      value <= (wdata & prog) | fixed;
    end
  end
endmodule

// File: rtl/pci_bar_bank.sv
module pci_bar_bank
  import pci_bar_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int NUM_BARS  = 6,
  parameter int BASE_OFFS = 16,
  parameter logic [NUM_BARS*DW-1:0] MASKS = {
    32'h0000_0000, 32'hFFFF_0002, 32'hFFFF_FFFF,
    32'hFFFF_F00C, 32'hFFFF_FF01, 32'hFF00_0000},
  localparam int IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  output logic             cfg_rvalid,
  output logic             chg_pulse,
  output logic [IDX_W-1:0] chg_idx,
  output logic             cfg_err
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  bar_type_e        typ [NUM_BARS];
  logic             mask_err;
  logic [DW-1:0]    vals [NUM_BARS];
  logic [NUM_BARS-1:0] live;
  logic             probe;

  bar_addr_decode #(
    .AW(AW), .NUM_BARS(NUM_BARS), .BASE_OFFS(BASE_OFFS)
  ) u_dec (
    .addr(cfg_addr), .hit(hit), .idx(idx)
  );

  bar_classify #(
    .DW(DW), .NUM_BARS(NUM_BARS), .MASKS(MASKS)
  ) u_cls (
    .typ(typ), .err(mask_err)
  );

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_slot
    assign live[g] = (typ[g] != BT_NONE);
    bar_slot #(
      .DW(DW), .MASK(MASKS[g*DW +: DW])
    ) u_slot (
      .clk(clk),
      .rst(rst),
      .typ(typ[g]),
      .wr_en(cfg_wr && hit && (idx == IDX_W'(g))),
      .wdata(cfg_wdata),
      .value(vals[g])
    );
  end

  assign probe = (cfg_wdata == {DW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_pulse  <= 1'b0;
      chg_idx    <= '0;
      cfg_rdata  <= '0;
      cfg_rvalid <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      chg_pulse  <= cfg_wr && hit && live[idx] && !probe;
      chg_idx    <= idx;
      cfg_rvalid <= cfg_rd && hit;
      cfg_rdata  <= (cfg_rd && hit) ? vals[idx] : '0;
      cfg_err    <= cfg_err | mask_err;
    end
  end
endmodule

// File: rtl/pci_bar_bank_chk.sv
module pci_bar_bank_chk #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int NUM_BARS = 6,
  parameter int BASE_OFFS = 16,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic             cfg_rd,
  input logic [AW-1:0]    cfg_addr,
  input logic [DW-1:0]    cfg_wdata,
  input logic             cfg_rvalid,
  input logic             chg_pulse,
  input logic [IDX_W-1:0] chg_idx,
  input logic             cfg_err
);
  localparam int LAST_OFFS = BASE_OFFS + 4 * NUM_BARS;

  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    chg_pulse |-> $past(cfg_wr)); // R9
  AST_PROBE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_wdata == {DW{1'b1}}) |=> !chg_pulse); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    chg_pulse |-> (int'(chg_idx) < NUM_BARS)); // R9
  AST_RVALID_NEEDS_RD: assert property (@(posedge clk) disable iff (rst)
    cfg_rvalid |-> $past(cfg_rd)); // R10
  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && (int'(cfg_addr) < BASE_OFFS || int'(cfg_addr) >= LAST_OFFS))
      |=> !cfg_rvalid); // R1
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R7
endmodule

bind pci_bar_bank pci_bar_bank_chk #(
  .DW(DW), .AW(AW), .NUM_BARS(NUM_BARS), .BASE_OFFS(BASE_OFFS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid),
  .chg_pulse(chg_pulse), .chg_idx(chg_idx), .cfg_err(cfg_err)
);

// File: tb/test_pci_bar_bank.sv
module test_pci_bar_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr, cfg_rd;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] rdata, b_rdata;
  logic        rvalid, b_rvalid, pulse, b_pulse, err, b_err;
  logic [2:0]  cidx, b_cidx;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_bar_bank i_pci_bar_bank (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata),
    .cfg_rvalid(rvalid), .chg_pulse(pulse), .chg_idx(cidx), .cfg_err(err)
  );

  // faulty mask set: type 3, 64-bit with zero next, io32, 64-bit on last
  pci_bar_bank #(.MASKS({
    32'hFFFF_FF04, 32'h0000_0000, 32'hFFFF_0001,
    32'h0000_0000, 32'hFFFF_FF04, 32'hFFFF_F006})
  ) i_bad (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(b_rdata),
    .cfg_rvalid(b_rvalid), .chg_pulse(b_pulse), .chg_idx(b_cidx), .cfg_err(b_err)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rexp;
    logic        pexp;
    logic [2:0]  iexp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{8'h10, 32'h1234_5678, 32'h1200_0000, 1'b1, 3'd0},  // R5 mem32
    '{8'h10, 32'hFFFF_FFFF, 32'hFF00_0000, 1'b0, 3'd0},  // R8 probe
    '{8'h14, 32'h0000_ABCD, 32'h0000_AB01, 1'b1, 3'd1},  // R4 io
    '{8'h14, 32'hFFFF_FFFF, 32'hFFFF_FF01, 1'b0, 3'd1},  // R8
    '{8'h18, 32'hDEAD_BEEF, 32'hDEAD_B00C, 1'b1, 3'd2},  // R5 64 low
    '{8'h1C, 32'h0000_0007, 32'h0000_0007, 1'b1, 3'd3},  // R6 upper half
    '{8'h1C, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 3'd3},  // R6 R8
    '{8'h20, 32'h000A_BCDE, 32'h000A_0002, 1'b1, 3'd4},  // R5 below 1MB
    '{8'h24, 32'hAAAA_AAAA, 32'h0000_0000, 1'b0, 3'd5},  // R3 idle
    '{8'h17, 32'h0000_1200, 32'h0000_1201, 1'b1, 3'd1}   // R1 low bits ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset values
    do_read(8'h10); check("R2 bar0", rdata, 32'h0000_0000);
    do_read(8'h14); check("R2 bar1", rdata, 32'h0000_0001);
    do_read(8'h18); check("R2 bar2", rdata, 32'h0000_000C);
    do_read(8'h1C); check("R2 bar3", rdata, 32'h0000_0000);
    do_read(8'h20); check("R2 bar4", rdata, 32'h0000_0002);
    check("R10 rvalid", {31'd0, rvalid}, 32'd1);
    check("R7 no error", {31'd0, err}, 32'd0);

    // R1 reads outside the range
    do_read(8'h0C);
    check("R1 below rvalid", {31'd0, rvalid}, 32'd0);
    check("R1 below rdata", rdata, 32'd0);
    do_read(8'h28);
    check("R1 above rvalid", {31'd0, rvalid}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i].addr, VEC[i].wdata);
      check("R9 pulse", {31'd0, pulse}, {31'd0, VEC[i].pexp});
      if (VEC[i].pexp) check("R9 idx", {29'd0, cidx}, {29'd0, VEC[i].iexp});
      @(negedge clk);
      check("R9 one cycle", {31'd0, pulse}, 32'd0);
      do_read(VEC[i].addr);
      check("R10 data", rdata, VEC[i].rexp);
    end

    // R7 faulty configuration
    check("R7 sticky error", {31'd0, b_err}, 32'd1);
    do_write(8'h10, 32'h1234_5000);
    check("R7 type3 no pulse", {31'd0, b_pulse}, 32'd0);
    do_read(8'h10); check("R7 type3 idle", b_rdata, 32'd0);
    do_read(8'h14); check("R7 pair idle", b_rdata, 32'd0);
    do_write(8'h24, 32'h5555_0000);
    check("R7 last 64 no pulse", {31'd0, b_pulse}, 32'd0);
    do_read(8'h24); check("R7 last 64 idle", b_rdata, 32'd0);
    do_write(8'h1C, 32'h1234_5678);
    check("R4 io32 pulse", {31'd0, b_pulse}, 32'd1);
    check("R4 io32 idx", {29'd0, b_cidx}, 32'd3);
    do_read(8'h1C); check("R4 io32 data", b_rdata, 32'h1234_0001);
    repeat (3) @(negedge clk);
    check("R7 still set", {31'd0, b_err}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule